// File: doc/BRIEF.md
# Rising-Edge Event Trigger with Set/Clear Mask Aliases

This block watches a bank of general-purpose input pins and emits one event pulse per pin whenever that pin goes from low to high, provided rising-edge detection has been armed for the pin. Each pin first passes through a chain of flip-flops that brings it into the clock domain. An edge is then detected by comparing the current synchronised sample with the previous one.

The arming mask cannot be written as a whole. Software changes it through two alias locations on a small memory-mapped bus. Writing ones to the arm alias sets the matching mask bits. Writing ones to the disarm alias clears them. Zero bits leave the mask as it was. Reading either alias returns the live mask rather than the last value written. This lets separate software agents arm or disarm their own pins without a read-modify-write race.

Top module: `rise_trig_top`

## Requirements
- R1: After reset the mask is all zeros, `evt_o` is all zeros, both aliases read 0, and a rising edge on any pin produces no event.
- R2: A write to offset 0x0 (arm alias) sets every mask bit n for which write-data bit n is 1. Bits written as 0 keep their previous value.
- R3: A write to offset 0x4 (disarm alias) clears every mask bit n for which write-data bit n is 1. Bits written as 0 keep their previous value.
- R4: A read of offset 0x0 or 0x4 returns the current mask in bits 15..0 of `rd_data_o`, in the cycle after `rd_en_i` is high. In cycles that do not follow a read, `rd_data_o` is 0.
- R5: Bits 31..16 of `rd_data_o` always read 0. Write-data bits 31..16 have no effect on the mask.
- R6: A read of any offset other than 0x0 and 0x4 returns 0. A write to any such offset leaves the mask unchanged.
- R7: When a pin changes from 0 to 1 and stays at 1, and its mask bit is 1, `evt_o[n]` is high for exactly one cycle. That cycle follows the third rising clock edge after the change.
- R8: No event is produced for a pin whose mask bit is 0, for a falling edge, or for a pin that stays high.
- R9: An edge on pin n affects only `evt_o[n]`. When several pins rise together, the event vector equals the mask ANDed with the set of pins that rose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 16 | Asynchronous input pins |
| addr_i | input | 4 | Byte offset for reads and writes |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Registered read data |
| evt_o | output | 16 | Per-pin single-cycle event pulses |

## Verification
The bench builds the block with its defaults: 16 pins, a 32-bit data word, a 4-bit offset and a two-stage synchroniser. The offset is only 4 bits wide, so the bench can sweep every one of the sixteen offsets to check that non-alias locations neither read nor write the mask. With 16 pins it can also arm each pin alone, and every pin but one, and check the exact event vector each time. Arithmetic mask patterns exercise partial arm and disarm writes, and every event is sampled at its computed latency and again one cycle later.

// File: rtl/rise_trig_pkg.sv
package rise_trig_pkg;

    localparam logic [31:0] ARM_OFS    = 32'h0;
    localparam logic [31:0] DISARM_OFS = 32'h4;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_ARM,
        SEL_DISARM
    } alias_sel_e;

    function automatic alias_sel_e decode_alias(input logic [31:0] ofs);
        if (ofs == ARM_OFS)
            return SEL_ARM;
        else if (ofs == DISARM_OFS)
            return SEL_DISARM;
        else
            return SEL_NONE;
    endfunction

endpackage

// File: rtl/rise_sync.sv
module rise_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst)
            stage_q[0] <= '0;
        else
            stage_q[0] <= async_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                stage_q[s] <= '0;
            else
                stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/rise_alias_regs.sv
module rise_alias_regs
    import rise_trig_pkg::*;
#(
    parameter int NUM_PINS = 16,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                wr_en_i,
    input  logic [DATA_W-1:0]   wr_data_i,
    input  logic                rd_en_i,
    output logic [DATA_W-1:0]   rd_data_o,
    output logic [NUM_PINS-1:0] mask_o
);
    alias_sel_e          sel;
    logic [NUM_PINS-1:0] wr_bits;
    logic [NUM_PINS-1:0] mask_q;

    assign sel     = decode_alias(32'(addr_i));
    assign wr_bits = wr_data_i[NUM_PINS-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (wr_en_i) begin
            case (sel)
                SEL_ARM:    mask_q <= mask_q | wr_bits;
                SEL_DISARM: mask_q <= mask_q & ~wr_bits;
                default:    mask_q <= mask_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_data_o <= '0;
        else if (rd_en_i && sel != SEL_NONE)
            rd_data_o <= DATA_W'(mask_q);
        else
            rd_data_o <= '0;
    end

    assign mask_o = mask_q;
endmodule

// File: rtl/rise_edge_evt.sv
module rise_edge_evt #(
    parameter int NUM_PINS = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] sync_i,
    input  logic [NUM_PINS-1:0] mask_i,
    output logic [NUM_PINS-1:0] prev_o,
    output logic [NUM_PINS-1:0] evt_o
);
    logic [NUM_PINS-1:0] prev_q;
    logic [NUM_PINS-1:0] rose;

    assign rose = sync_i & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            evt_o  <= '0;
        end else begin
            prev_q <= sync_i;
            evt_o  <= rose & mask_i;
        end
    end

    assign prev_o = prev_q;
endmodule

// File: rtl/rise_trig_top.sv
module rise_trig_top #(
    parameter int NUM_PINS    = 16,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                wr_en_i,
    input  logic [DATA_W-1:0]   wr_data_i,
    input  logic                rd_en_i,
    output logic [DATA_W-1:0]   rd_data_o,
    output logic [NUM_PINS-1:0] evt_o
);
    logic [NUM_PINS-1:0] trig_mask;
    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] pin_prev;

    rise_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst     (rst),
        .async_i (pin_i),
        .sync_o  (pin_sync)
    );

    rise_alias_regs #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .addr_i    (addr_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .rd_en_i   (rd_en_i),
        .rd_data_o (rd_data_o),
        .mask_o    (trig_mask)
    );

    rise_edge_evt #(.NUM_PINS(NUM_PINS)) edge_i (
        .clk    (clk),
        .rst    (rst),
        .sync_i (pin_sync),
        .mask_i (trig_mask),
        .prev_o (pin_prev),
        .evt_o  (evt_o)
    );
endmodule

// File: rtl/rise_trig_chk.sv
module rise_trig_chk #(
    parameter int NUM_PINS = 16,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 4
) (
    input logic                clk,
    input logic                rst,
    input logic [ADDR_W-1:0]   addr_i,
    input logic                wr_en_i,
    input logic [DATA_W-1:0]   wr_data_i,
    input logic [DATA_W-1:0]   rd_data_o,
    input logic [NUM_PINS-1:0] evt_o,
    input logic [NUM_PINS-1:0] trig_mask
);
    logic [NUM_PINS-1:0] wr_bits;
    logic                seen_rst;

    assign wr_bits = wr_data_i[NUM_PINS-1:0];

    always_ff @(posedge clk) seen_rst <= rst;

    always @(negedge clk) begin
        if (seen_rst === 1'b1 && rst === 1'b0) begin
            // R1
            reset_state_chk: assert (trig_mask == '0 && evt_o == '0 && rd_data_o == '0);
        end
    end

    // R2
    arm_sets_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && 32'(addr_i) == 32'h0) |=> ((trig_mask & $past(wr_bits)) == $past(wr_bits)));

    // R3
    disarm_clears_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && 32'(addr_i) == 32'h4) |=> ((trig_mask & $past(wr_bits)) == '0));

    // R5
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_data_o[DATA_W-1:NUM_PINS] == '0);

    // R6
    other_ofs_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && 32'(addr_i) != 32'h0 && 32'(addr_i) != 32'h4) |=> $stable(trig_mask));

    // R7
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((evt_o & $past(evt_o)) == '0));

    // R8
    masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((evt_o & ~$past(trig_mask)) == '0));
endmodule

bind rise_trig_top rise_trig_chk #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .addr_i    (addr_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o),
    .evt_o     (evt_o),
    .trig_mask (trig_mask)
);

// File: tb/rise_trig_top_tb_top.sv
`timescale 1ns/1ps
module rise_trig_top_tb_top;
    localparam int NP = 16;
    localparam int DW = 32;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic [NP-1:0] pin_i;
    logic [AW-1:0] addr_i;
    logic          wr_en_i;
    logic [DW-1:0] wr_data_i;
    logic          rd_en_i;
    logic [DW-1:0] rd_data_o;
    logic [NP-1:0] evt_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    rise_trig_top dut_i (
        .clk(clk), .rst(rst), .pin_i(pin_i), .addr_i(addr_i),
        .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_en_i(rd_en_i),
        .rd_data_o(rd_data_o), .evt_o(evt_o)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0; wr_data_i = '0; addr_i = '0;
    endtask

    task automatic bus_rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        addr_i = a; rd_en_i = 1'b1;
        @(negedge clk);
        rd_en_i = 1'b0; addr_i = '0;
        d = rd_data_o;
    endtask

    // raise pins from all-zero to 'rise', check pulse latency, then drop them
    task automatic edge_test(input string req, input logic [NP-1:0] rise, input logic [NP-1:0] exp);
        pin_i = rise;
        @(negedge clk); chk({req, " pre1"}, 32'(evt_o), 32'h0);
        @(negedge clk); chk({req, " pre2"}, 32'(evt_o), 32'h0);
        @(negedge clk); chk({req, " pulse"}, 32'(evt_o), 32'(exp));
        @(negedge clk); chk({req, " R7 one-cycle"}, 32'(evt_o), 32'h0);
        @(negedge clk); chk({req, " R8 held high"}, 32'(evt_o), 32'h0);
        pin_i = '0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); chk("R8 falling", 32'(evt_o), 32'h0);
        end
    endtask

    task automatic set_mask(input logic [NP-1:0] m);
        bus_wr(4'h4, 32'hFFFF_FFFF);
        bus_wr(4'h0, 32'(m));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] rd;
        rst = 1'b1; pin_i = '0; addr_i = '0; wr_en_i = 1'b0; wr_data_i = '0; rd_en_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 evt", 32'(evt_o), 32'h0);
        chk("R1 rd idle", rd_data_o, 32'h0);
        bus_rd(4'h0, rd); chk("R1 arm read", rd, 32'h0);
        bus_rd(4'h4, rd); chk("R1 disarm read", rd, 32'h0);
        edge_test("R1 no event", 16'hFFFF, 16'h0);

        // R4 read data returns to 0 the cycle after
        bus_wr(4'h0, 32'h0000_00F0);
        bus_rd(4'h0, rd); chk("R4 arm read", rd, 32'h0000_00F0);
        @(negedge clk); chk("R4 idle zero", rd_data_o, 32'h0);

        // R5 upper bits
        set_mask(16'h0);
        bus_wr(4'h0, 32'hFFFF_0000);
        bus_rd(4'h4, rd); chk("R5 upper write ignored", rd, 32'h0);
        bus_wr(4'h0, 32'hFFFF_FFFF);
        bus_rd(4'h0, rd); chk("R5 upper read zero", rd, 32'h0000_FFFF);

        // R2/R3 arithmetic patterns
        for (int k = 0; k < 8; k++) begin
            logic [NP-1:0] pat, sub, add;
            pat = NP'(k * 16'h1357) ^ 16'hA5A5;
            sub = NP'(k * 16'h0F1D) ^ 16'h3C3C;
            add = NP'(16'h0101 << k);
            set_mask('0);
            bus_wr(4'h0, {16'hDEAD, pat});
            bus_rd(4'h0, rd); chk("R2 arm", rd, 32'(pat));
            bus_wr(4'h4, 32'(sub));
            bus_rd(4'h4, rd); chk("R3 disarm", rd, 32'(pat & ~sub));
            bus_wr(4'h0, 32'(add));
            bus_rd(4'h0, rd); chk("R2 arm keeps", rd, 32'((pat & ~sub) | add));
        end

        // R6 every other offset
        set_mask(16'h5AC3);
        for (int a = 0; a < 16; a++) begin
            if (a != 0 && a != 4) begin
                bus_wr(AW'(a), 32'hFFFF_FFFF);
                bus_wr(AW'(a), 32'h0);
                bus_rd(AW'(a), rd); chk("R6 other read", rd, 32'h0);
                bus_rd(4'h4, rd);   chk("R6 mask unchanged", rd, 32'h5AC3);
            end
        end

        // R7/R9 each pin alone, and all-but-one
        for (int n = 0; n < NP; n++) begin
            logic [NP-1:0] one;
            one = NP'(1) << n;
            set_mask(one);
            edge_test("R9 single pin armed", 16'hFFFF, one);
            edge_test("R8 other pins only", ~one, 16'h0);
            set_mask(~one);
            edge_test("R9 all but one", 16'hFFFF, ~one);
        end

        // R9 mixed masks and rise sets
        for (int k = 0; k < 6; k++) begin
            logic [NP-1:0] m, r;
            m = NP'(k * 16'h2F4B) ^ 16'h9669;
            r = NP'(k * 16'h71C3) ^ 16'h0FF0;
            set_mask(m);
            edge_test("R9 mixed", r, m & r);
        end

        // R8 mask cleared -> no events
        set_mask(16'h0);
        edge_test("R8 disarmed", 16'hFFFF, 16'h0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule